// File: doc/BRIEF.md
# Secondary Interrupt Combiner with Pass-Through

This block gathers 32 level-sensitive interrupt lines in front of a primary vectored controller. Each line's level is captured into a raw-level register every cycle. An enable mask selects which captured lines take part in a single combined request, and that request is driven on output line 31. Ten lines, 21 through 30, can also be routed one by one to the output with the same index. This lets a chosen source reach the primary controller directly instead of through the combined request. Every other output line is held low.

Software controls the block through a single-cycle register port. The port carries a word address, 32-bit write data and separate read and write strobes, and read data comes back one cycle later from a register. The mask and the pass-through enables are changed only through set and clear words, so no read-modify-write is needed. The window is 4 KB, which is 1024 word addresses. Word offsets that are not used read as zero and ignore writes.

Top module: `sec_irq_combiner`

## Requirements
- R1: After reset the enable mask and the pass-through enables are zero, every bit of `irq_out` is low and `rd_data` is zero.
- R2: The raw-level register takes the value of `irq_in` at every rising clock edge. A read of word offset 1 returns it.
- R3: `irq_out[31]` is high exactly when the raw level ANDed with the enable mask is nonzero. It changes in the cycle after the input change or register write that causes it.
- R4: A read of offset 0 returns the raw level ANDed with the mask. A read of offset 2 returns the mask.
- R5: A write to offset 2 ORs the write data into the mask. A write to offset 3 clears each mask bit that is set in the write data.
- R6: A write of nonzero data to offset 4 sets mask bit 0, and a write of nonzero data to offset 5 clears it. A write of zero to either offset changes nothing. A read of offset 4 returns raw-level bit 0 in bit 0 and zeros in all other bits.
- R7: A write to offset 8 ORs only data bits 21 to 30 (0x7FE00000) into the pass-through enables. A read of offset 8 returns the pass-through enables.
- R8: A write to offset 9 clears each pass-through enable bit that is set in the write data.
- R9: For n from 21 to 30, `irq_out[n]` equals raw bit n when pass-through enable n is set, and is low otherwise. `irq_out[20:0]` is always low. Raw bit 31 reaches `irq_out[31]` only through the mask.
- R10: Reads of offsets 3, 5, 6, 7 and 9 to 1023 return zero. Writes to offsets 0, 1, 6, 7 and 10 to 1023 change no state.
- R11: `rd_data` is loaded only in the cycle that `rd_en` is sampled high, and keeps its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 32 | Level-sensitive interrupt sources |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 10 | Word offset inside the 4 KB window |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq_out | output | 32 | Pass-through lines 21..30 and combined request on 31 |

## Verification
An input change is captured at the next rising edge, and `irq_out` shows the new value right after that edge. A register write takes effect at the edge where the strobe is sampled, and every output that depends on it changes in that same cycle. Read data is valid just after the edge that samples `rd_en`. The bench drives every stimulus on a falling edge and holds it for one full cycle. It then samples on the next falling edge, which is half a cycle after the edge where each result is due.

// File: rtl/sic_pkg.sv
package sic_pkg;
   // Word offsets decoded by the register port
   typedef enum logic [3:0] {
      SEL_STATUS   = 4'd0,
      SEL_RAW      = 4'd1,
      SEL_MASK_SET = 4'd2,
      SEL_MASK_CLR = 4'd3,
      SEL_SOFT_SET = 4'd4,
      SEL_SOFT_CLR = 4'd5,
      SEL_PT_SET   = 4'd8,
      SEL_PT_CLR   = 4'd9,
      SEL_NONE     = 4'd15
   } reg_sel_e;

   function automatic reg_sel_e decode_sel(input int unsigned word_off);
      case (word_off)
         0: decode_sel = SEL_STATUS;
         1: decode_sel = SEL_RAW;
         2: decode_sel = SEL_MASK_SET;
         3: decode_sel = SEL_MASK_CLR;
         4: decode_sel = SEL_SOFT_SET;
         5: decode_sel = SEL_SOFT_CLR;
         8: decode_sel = SEL_PT_SET;
         9: decode_sel = SEL_PT_CLR;
         default: decode_sel = SEL_NONE;
      endcase
   endfunction
endpackage

// File: rtl/sic_level_latch.sv
module sic_level_latch #(
   parameter int NUM_LINES = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lines_in,
   output logic [NUM_LINES-1:0] raw_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= lines_in;
   end
endmodule

// File: rtl/sic_regs.sv
module sic_regs
   import sic_pkg::*;
#(
   parameter int NUM_LINES = 32,
   parameter int ADDR_W    = 10,
   parameter int PT_LO     = 21,
   parameter int PT_HI     = 30
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [NUM_LINES-1:0] wr_data,
   input  logic [NUM_LINES-1:0] raw,
   output logic [NUM_LINES-1:0] mask_q,
   output logic [NUM_LINES-1:0] pt_en_q,
   output logic [NUM_LINES-1:0] rd_data_q
);
   localparam logic [NUM_LINES-1:0] PT_FIELD =
      ((NUM_LINES'(1) << (PT_HI + 1)) - NUM_LINES'(1)) &
      ~((NUM_LINES'(1) << PT_LO) - NUM_LINES'(1));

   reg_sel_e sel;
   logic     data_nz;
   logic [NUM_LINES-1:0] rd_mux;

   assign sel     = decode_sel(int'(addr));
   assign data_nz = |wr_data;

   always_comb begin
      case (sel)
         SEL_STATUS:   rd_mux = raw & mask_q;
         SEL_RAW:      rd_mux = raw;
         SEL_MASK_SET: rd_mux = mask_q;
         SEL_SOFT_SET: rd_mux = {{(NUM_LINES-1){1'b0}}, raw[0]};
         SEL_PT_SET:   rd_mux = pt_en_q;
         default:      rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         pt_en_q <= '0;
      end else if (wr_en) begin
         case (sel)
            SEL_MASK_SET: mask_q <= mask_q | wr_data;
            SEL_MASK_CLR: mask_q <= mask_q & ~wr_data;
            SEL_SOFT_SET: if (data_nz) mask_q[0] <= 1'b1;
            SEL_SOFT_CLR: if (data_nz) mask_q[0] <= 1'b0;
            SEL_PT_SET:   pt_en_q <= pt_en_q | (wr_data & PT_FIELD);
            SEL_PT_CLR:   pt_en_q <= pt_en_q & ~wr_data;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data_q <= '0;
      else if (rd_en) rd_data_q <= rd_mux;
   end
endmodule

// File: rtl/sic_out_drive.sv
module sic_out_drive #(
   parameter int NUM_LINES = 32,
   parameter int PT_LO     = 21,
   parameter int PT_HI     = 30,
   parameter int COMB_IDX  = 31
) (
   input  logic [NUM_LINES-1:0] raw,
   input  logic [NUM_LINES-1:0] mask,
   input  logic [NUM_LINES-1:0] pt_en,
   output logic [NUM_LINES-1:0] lines_out
);
   logic any_masked;
   assign any_masked = |(raw & mask);

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      if (g == COMB_IDX) begin : g_comb
         assign lines_out[g] = any_masked;
      end else if (g >= PT_LO && g <= PT_HI) begin : g_pass
         assign lines_out[g] = raw[g] & pt_en[g];
      end else begin : g_idle
         assign lines_out[g] = 1'b0;
      end
   end
endmodule

// File: rtl/sec_irq_combiner.sv
module sec_irq_combiner #(
   parameter int NUM_LINES = 32,
   parameter int ADDR_W    = 10,
   parameter int PT_LO     = 21,
   parameter int PT_HI     = 30,
   parameter int COMB_IDX  = 31
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [NUM_LINES-1:0] wr_data,
   output logic [NUM_LINES-1:0] rd_data,
   output logic [NUM_LINES-1:0] irq_out
);
   if (PT_LO > PT_HI || PT_HI >= NUM_LINES) begin : g_bad_range
      $error("pass-through range must lie inside the line count");
   end
   if (COMB_IDX >= NUM_LINES || (COMB_IDX >= PT_LO && COMB_IDX <= PT_HI)) begin : g_bad_comb
      $error("combined line must be a valid line outside the pass-through range");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("address must reach word offset 9");
   end

   logic [NUM_LINES-1:0] raw_q, mask_q, pt_en_q;

   sic_level_latch #(.NUM_LINES(NUM_LINES)) u_latch (
      .clk(clk), .rst_n(rst_n), .lines_in(irq_in), .raw_q(raw_q)
   );

   sic_regs #(
      .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .PT_LO(PT_LO), .PT_HI(PT_HI)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wr_data(wr_data), .raw(raw_q), .mask_q(mask_q), .pt_en_q(pt_en_q),
      .rd_data_q(rd_data)
   );

   sic_out_drive #(
      .NUM_LINES(NUM_LINES), .PT_LO(PT_LO), .PT_HI(PT_HI), .COMB_IDX(COMB_IDX)
   ) u_out (
      .raw(raw_q), .mask(mask_q), .pt_en(pt_en_q), .lines_out(irq_out)
   );
endmodule

// File: rtl/sec_irq_combiner_chk.sv
module sec_irq_combiner_chk #(
   parameter int NUM_LINES = 32,
   parameter int ADDR_W    = 10,
   parameter int PT_LO     = 21,
   parameter int PT_HI     = 30,
   parameter int COMB_IDX  = 31
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] irq_in,
   input logic                 wr_en,
   input logic                 rd_en,
   input logic [ADDR_W-1:0]    addr,
   input logic [NUM_LINES-1:0] wr_data,
   input logic [NUM_LINES-1:0] rd_data,
   input logic [NUM_LINES-1:0] irq_out
);
   localparam int PT_N = PT_HI - PT_LO + 1;

   // R3: the combined request needs some line high one cycle earlier
   a_r3_comb_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out[COMB_IDX] |-> ($past(irq_in) != '0));

   // R9: a pass-through output is high only if its input was high one cycle earlier
   a_r9_pass_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out[PT_HI:PT_LO] & ~$past(irq_in[PT_HI:PT_LO])) == PT_N'(0));

   // R11: read data holds while no read is sampled
   a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   // R8: clearing every pass-through enable silences the pass-through outputs
   a_r8_pt_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(9) && (&wr_data)) |=> (irq_out[PT_HI:PT_LO] == PT_N'(0)));

   // R5: clearing the whole mask drops the combined request
   a_r5_mask_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(3) && (&wr_data)) |=> !irq_out[COMB_IDX]);
endmodule

bind sec_irq_combiner sec_irq_combiner_chk #(
   .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .PT_LO(PT_LO), .PT_HI(PT_HI),
   .COMB_IDX(COMB_IDX)
) chk_i (
   .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
   .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
);

// File: tb/sec_irq_combiner_tb_top.sv
module sec_irq_combiner_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_in = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [9:0]  addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [31:0] irq_out;

   int n_checks = 0;
   int n_fails  = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sec_irq_combiner dut_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input int unsigned a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = 10'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic reg_rd(input int unsigned a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = 10'(a);
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic set_in(input logic [31:0] v);
      @(negedge clk);
      irq_in = v;
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R1 rd_data after reset", rd_data, 32'h0);
      check("R1 irq_out after reset", irq_out, 32'h0);
      reg_rd(2, d); check("R1 mask after reset", d, 32'h0);
      reg_rd(8, d); check("R1 pass enable after reset", d, 32'h0);
   endtask

   task automatic t_raw_and_mask();
      logic [31:0] d;
      set_in(32'hA5A5_0F0F);
      reg_rd(1, d); check("R2 raw level read", d, 32'hA5A5_0F0F);
      reg_rd(0, d); check("R4 status with empty mask", d, 32'h0);
      check("R3 no request with empty mask", irq_out, 32'h0);
      reg_wr(2, 32'h0000_0F00);
      reg_rd(2, d); check("R5 mask set", d, 32'h0000_0F00);
      check("R3 request on mask write", irq_out, 32'h8000_0000);
      reg_wr(2, 32'h0000_0003);
      reg_rd(2, d); check("R5 mask set ORs", d, 32'h0000_0F03);
      reg_rd(0, d); check("R4 masked status", d, 32'h0000_0F03);
      reg_wr(3, 32'h0000_0F00);
      reg_rd(2, d); check("R5 mask clear", d, 32'h0000_0003);
      check("R3 request still on", irq_out, 32'h8000_0000);
      set_in(32'h0);
      check("R3 request drops with inputs", irq_out, 32'h0);
      set_in(32'h0000_0002);
      check("R3 request on single line", irq_out, 32'h8000_0000);
      reg_wr(3, 32'hFFFF_FFFF);
      check("R3 request drops with mask", irq_out, 32'h0);
   endtask

   task automatic t_soft();
      logic [31:0] d;
      reg_wr(4, 32'h0);
      reg_rd(2, d); check("R6 zero soft set ignored", d, 32'h0);
      reg_wr(4, 32'h0000_0005);
      reg_rd(2, d); check("R6 soft set", d, 32'h0000_0001);
      reg_wr(5, 32'h0);
      reg_rd(2, d); check("R6 zero soft clear ignored", d, 32'h0000_0001);
      reg_wr(5, 32'h0000_0008);
      reg_rd(2, d); check("R6 soft clear", d, 32'h0);
      set_in(32'hFFFF_FFFF);
      reg_rd(4, d); check("R6 soft read bit0 high", d, 32'h0000_0001);
      set_in(32'hFFFF_FFFE);
      reg_rd(4, d); check("R6 soft read bit0 low", d, 32'h0);
   endtask

   task automatic t_pass();
      logic [31:0] d;
      set_in(32'h0);
      reg_wr(8, 32'hFFFF_FFFF);
      reg_rd(8, d); check("R7 pass set limited field", d, 32'h7FE0_0000);
      check("R9 pass outputs low with low inputs", irq_out, 32'h0);
      set_in(32'hFFFF_FFFF);
      check("R9 pass outputs follow, raw 31 unmasked", irq_out, 32'h7FE0_0000);
      reg_wr(9, 32'h0020_0000);
      reg_rd(8, d); check("R8 pass clear", d, 32'h7FC0_0000);
      check("R9 cleared line driven low", irq_out, 32'h7FC0_0000);
      reg_wr(2, 32'h8000_0000);
      check("R9 line 31 via mask only", irq_out, 32'hFFC0_0000);
      set_in(32'h0010_0000);
      check("R9 low lines stay low", irq_out, 32'h0);
      reg_wr(3, 32'hFFFF_FFFF);
      reg_wr(9, 32'hFFFF_FFFF);
   endtask

   task automatic t_undef();
      logic [31:0] d;
      reg_wr(2, 32'h0000_00F0);
      reg_wr(8, 32'h0060_0000);
      reg_wr(0, 32'hFFFF_FFFF);
      reg_wr(1, 32'hFFFF_FFFF);
      reg_wr(6, 32'hFFFF_FFFF);
      reg_wr(7, 32'hFFFF_FFFF);
      reg_wr(10, 32'hFFFF_FFFF);
      reg_wr(1023, 32'hFFFF_FFFF);
      reg_rd(2, d); check("R10 mask untouched", d, 32'h0000_00F0);
      reg_rd(8, d); check("R10 pass untouched", d, 32'h0060_0000);
      reg_rd(3, d); check("R10 offset 3 reads zero", d, 32'h0);
      reg_rd(5, d); check("R10 offset 5 reads zero", d, 32'h0);
      reg_rd(9, d); check("R10 offset 9 reads zero", d, 32'h0);
      reg_rd(1023, d); check("R10 last offset reads zero", d, 32'h0);
   endtask

   task automatic t_hold();
      logic [31:0] d;
      set_in(32'h1234_5678);
      reg_rd(1, d); check("R11 read value", d, 32'h1234_5678);
      set_in(32'h0);
      reg_wr(2, 32'hFFFF_FFFF);
      repeat (3) @(negedge clk);
      check("R11 rd_data held", rd_data, 32'h1234_5678);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_raw_and_mask();
      t_soft();
      t_pass();
      t_undef();
      t_hold();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule